// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits beside the execute stage of a five-stage in-order pipeline. It resolves read-after-write hazards without stalling. For each ALU source operand it compares the source register index of the instruction now in execute with the destination indices of the two older instructions still in flight: the one in the memory stage and the one in write-back. It then steers a three-input operand multiplexer that picks one of three values: the value read from the register file, the memory-stage ALU result, or the write-back value. When both older instructions target the same register, the younger producer (the memory stage) wins.

The block also holds the same-cycle bypass for the register-file read in decode. If write-back writes a register in the cycle that decode reads it, decode receives the value being written and not the stale array content. The logic is purely combinational, so every output follows its inputs within the same cycle. The number of source operands, the data width, the register-index width and the hard-wired-zero guard are parameters.

Top module: `fwd_unit`

## Requirements
- R1: With no qualifying match for a source, its select is 2'b00 and the operand equals that source's register-file value.
- R2: A source whose index equals the memory-stage destination, while the memory-stage write enable is 1, gets select 2'b10 and the operand equals the memory-stage result.
- R3: A source that matches the write-back destination (write-back enable 1) and has no qualifying memory-stage match gets select 2'b01 and the operand equals the write-back value.
- R4: When a source matches both the memory-stage and the write-back destination with both enables set, the memory stage has priority and the select is 2'b10.
- R5: A stage whose write enable is 0 never causes a forward, even if its destination index matches.
- R6: A destination index of 0 never causes a forward or a decode bypass (register 0 is hard-wired to zero).
- R7: Each source operand is resolved independently, so in the same cycle one source may be forwarded from the memory stage while the other comes from write-back or from the register file.
- R8: In decode, a read whose index equals the write-back destination, while the write-back enable is 1 and the index is nonzero, returns the write-back value instead of the raw register-file read.
- R9: A decode read returns the raw register-file data unchanged when the write-back enable is 0 or the indices differ.
- R10: The select value 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_reg | input | NUM_SRC x REG_W | Source register indices of the instruction in execute |
| ex_src_rfval | input | NUM_SRC x DATA_W | Register-file values carried into execute for those sources |
| mem_dst_reg | input | REG_W | Destination index of the instruction in the memory stage |
| mem_wr_en | input | 1 | Register-write flag of the memory-stage instruction |
| mem_result | input | DATA_W | ALU result held in the memory stage |
| wb_dst_reg | input | REG_W | Destination index of the instruction in write-back |
| wb_wr_en | input | 1 | Register-write flag of the write-back instruction |
| wb_value | input | DATA_W | Value being written back |
| id_src_reg | input | NUM_SRC x REG_W | Source indices being read in decode |
| id_rf_raw | input | NUM_SRC x DATA_W | Raw register-array read data in decode |
| id_src_val | output | NUM_SRC x DATA_W | Decode read data after the write-before-read bypass |
| ex_fwd_sel | output | NUM_SRC x 2 | Per-operand select: 00 register file, 10 memory stage, 01 write-back |
| ex_operand | output | NUM_SRC x DATA_W | Per-operand value sent to the ALU |

## Verification
The unit holds no state, so an internal fault shows at the ports in the same cycle as the stimulus that exposes it. A wrong comparison or a broken priority shows up as a select code that disagrees with the register indices and enables. A broken multiplexer leg shows up as an operand that disagrees with its own select code. The vector table sets each operand against matches in neither stage, in one stage, or in both stages, with the enables on and off and with register 0 as the index, so that a swapped priority or a missing zero guard changes an observed select or operand value. Directed cases then cover the decode bypass with a match, with the enable off, and with index 0.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      FSEL_RF  = 2'b00,
      FSEL_WB  = 2'b01,
      FSEL_MEM = 2'b10
   } fsel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
   parameter int REG_W      = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wen,
   output logic             hit
);
   logic same;
   assign same = (src == dst);

   generate
      if (ZERO_GUARD) begin : g_guard
         assign hit = wen && same && (dst != '0);
      end else begin : g_plain
         assign hit = wen && same;
      end
   endgenerate
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
   import fwd_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wen,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             wb_wen,
   output fsel_e            sel
);
   logic mem_hit;
   logic wb_hit;

   fwd_hit #(.REG_W(REG_W), .ZERO_GUARD(ZERO_GUARD)) u_mem_hit (
      .src(src), .dst(mem_dst), .wen(mem_wen), .hit(mem_hit)
   );
   fwd_hit #(.REG_W(REG_W), .ZERO_GUARD(ZERO_GUARD)) u_wb_hit (
      .src(src), .dst(wb_dst), .wen(wb_wen), .hit(wb_hit)
   );

   // younger producer first
   always_comb begin
      if (mem_hit)     sel = FSEL_MEM;
      else if (wb_hit) sel = FSEL_WB;
      else             sel = FSEL_RF;
   end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
   import fwd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  fsel_e              sel,
   input  logic [DATA_W-1:0]  rf_val,
   input  logic [DATA_W-1:0]  mem_val,
   input  logic [DATA_W-1:0]  wb_val,
   output logic [DATA_W-1:0]  y
);
   always_comb begin
      unique case (sel)
         FSEL_MEM: y = mem_val;
         FSEL_WB:  y = wb_val;
         default:  y = rf_val;
      endcase
   end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
   parameter int DATA_W     = 32,
   parameter int REG_W      = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [REG_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] rd_raw,
   input  logic [REG_W-1:0]  wr_idx,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_val,
   output logic [DATA_W-1:0] rd_val
);
   logic take_new;

   fwd_hit #(.REG_W(REG_W), .ZERO_GUARD(ZERO_GUARD)) u_hit (
      .src(rd_idx), .dst(wr_idx), .wen(wr_en), .hit(take_new)
   );

   assign rd_val = take_new ? wr_val : rd_raw;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int REG_W      = 5,
   parameter int NUM_SRC    = 2,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_W-1:0]  ex_src_reg,
   input  logic [NUM_SRC-1:0][DATA_W-1:0] ex_src_rfval,
   input  logic [REG_W-1:0]               mem_dst_reg,
   input  logic                           mem_wr_en,
   input  logic [DATA_W-1:0]              mem_result,
   input  logic [REG_W-1:0]               wb_dst_reg,
   input  logic                           wb_wr_en,
   input  logic [DATA_W-1:0]              wb_value,
   input  logic [NUM_SRC-1:0][REG_W-1:0]  id_src_reg,
   input  logic [NUM_SRC-1:0][DATA_W-1:0] id_rf_raw,
   output logic [NUM_SRC-1:0][DATA_W-1:0] id_src_val,
   output logic [NUM_SRC-1:0][1:0]        ex_fwd_sel,
   output logic [NUM_SRC-1:0][DATA_W-1:0] ex_operand
);
   localparam int NUM_REGS = 1 << REG_W;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("fwd_unit: DATA_W must be at least 1");
      end
      if (REG_W < 1 || NUM_REGS < 2) begin : g_bad_reg
         $error("fwd_unit: REG_W must be at least 1");
      end
      if (NUM_SRC < 1) begin : g_bad_src
         $error("fwd_unit: NUM_SRC must be at least 1");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         fsel_e sel_i;

         fwd_pick #(.REG_W(REG_W), .ZERO_GUARD(ZERO_GUARD)) u_pick (
            .src    (ex_src_reg[i]),
            .mem_dst(mem_dst_reg),
            .mem_wen(mem_wr_en),
            .wb_dst (wb_dst_reg),
            .wb_wen (wb_wr_en),
            .sel    (sel_i)
         );

         fwd_opmux #(.DATA_W(DATA_W)) u_mux (
            .sel    (sel_i),
            .rf_val (ex_src_rfval[i]),
            .mem_val(mem_result),
            .wb_val (wb_value),
            .y      (ex_operand[i])
         );

         rf_bypass #(.DATA_W(DATA_W), .REG_W(REG_W), .ZERO_GUARD(ZERO_GUARD)) u_byp (
            .rd_idx(id_src_reg[i]),
            .rd_raw(id_rf_raw[i]),
            .wr_idx(wb_dst_reg),
            .wr_en (wb_wr_en),
            .wr_val(wb_value),
            .rd_val(id_src_val[i])
         );

         assign ex_fwd_sel[i] = sel_i;
      end
   endgenerate
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int DATA_W     = 32,
   parameter int REG_W      = 5,
   parameter int NUM_SRC    = 2,
   parameter bit ZERO_GUARD = 1'b1
) (
   input logic [NUM_SRC-1:0][REG_W-1:0]  ex_src_reg,
   input logic [NUM_SRC-1:0][DATA_W-1:0] ex_src_rfval,
   input logic [REG_W-1:0]               mem_dst_reg,
   input logic                           mem_wr_en,
   input logic [DATA_W-1:0]              mem_result,
   input logic [REG_W-1:0]               wb_dst_reg,
   input logic                           wb_wr_en,
   input logic [DATA_W-1:0]              wb_value,
   input logic [NUM_SRC-1:0][REG_W-1:0]  id_src_reg,
   input logic [NUM_SRC-1:0][DATA_W-1:0] id_rf_raw,
   input logic [NUM_SRC-1:0][DATA_W-1:0] id_src_val,
   input logic [NUM_SRC-1:0][1:0]        ex_fwd_sel,
   input logic [NUM_SRC-1:0][DATA_W-1:0] ex_operand
);
   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         if (!$isunknown({ex_src_reg[i], ex_src_rfval[i], mem_dst_reg, mem_wr_en,
                          mem_result, wb_dst_reg, wb_wr_en, wb_value,
                          ex_fwd_sel[i], ex_operand[i]})) begin
            // R10
            no_illegal_sel_chk: assert (ex_fwd_sel[i] != 2'b11);
            // R1
            rf_leg_chk: assert (ex_fwd_sel[i] != 2'b00 || ex_operand[i] == ex_src_rfval[i]);
            // R2
            mem_leg_chk: assert (ex_fwd_sel[i] != 2'b10 || ex_operand[i] == mem_result);
            // R3
            wb_leg_chk: assert (ex_fwd_sel[i] != 2'b01 || ex_operand[i] == wb_value);
            // R5
            mem_needs_wen_chk: assert (ex_fwd_sel[i] != 2'b10 || mem_wr_en);
            // R5
            wb_needs_wen_chk: assert (ex_fwd_sel[i] != 2'b01 || wb_wr_en);
            // R6
            zero_no_fwd_chk: assert (!ZERO_GUARD || ex_src_reg[i] != '0 || ex_fwd_sel[i] == 2'b00);
            // R4
            mem_priority_chk: assert (!(mem_wr_en && mem_dst_reg == ex_src_reg[i]
                                        && (mem_dst_reg != '0 || !ZERO_GUARD))
                                      || ex_fwd_sel[i] == 2'b10);
         end
         if (!$isunknown({id_src_reg[i], id_rf_raw[i], id_src_val[i],
                          wb_dst_reg, wb_wr_en, wb_value})) begin
            // R9
            byp_raw_chk: assert (wb_wr_en && id_src_reg[i] == wb_dst_reg
                                 || id_src_val[i] == id_rf_raw[i]);
            // R8
            byp_new_chk: assert (!(wb_wr_en && id_src_reg[i] == wb_dst_reg
                                   && (wb_dst_reg != '0 || !ZERO_GUARD))
                                 || id_src_val[i] == wb_value);
         end
      end
   end
endmodule

bind fwd_unit fwd_unit_chk #(
   .DATA_W(DATA_W), .REG_W(REG_W), .NUM_SRC(NUM_SRC), .ZERO_GUARD(ZERO_GUARD)
) u_chk (.*);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
   localparam int DW = 32;
   localparam int RW = 5;
   localparam int NS = 2;
   localparam int NV = 10;

   // {rs, rt, mem_dst, mem_en, wb_dst, wb_en, exp_sel_a, exp_sel_b}
   localparam logic [25:0] VEC [0:NV-1] = '{
      {5'd3,  5'd4,  5'd3,  1'b1, 5'd9,  1'b1, 2'b10, 2'b00}, // R2
      {5'd3,  5'd4,  5'd7,  1'b1, 5'd4,  1'b1, 2'b00, 2'b01}, // R3
      {5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'b10, 2'b10}, // R4
      {5'd5,  5'd6,  5'd5,  1'b0, 5'd5,  1'b1, 2'b01, 2'b00}, // R5
      {5'd5,  5'd6,  5'd5,  1'b0, 5'd5,  1'b0, 2'b00, 2'b00}, // R5
      {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R6
      {5'd0,  5'd8,  5'd0,  1'b1, 5'd8,  1'b1, 2'b00, 2'b01}, // R6 R7
      {5'd1,  5'd2,  5'd2,  1'b1, 5'd1,  1'b1, 2'b01, 2'b10}, // R7
      {5'd31, 5'd30, 5'd31, 1'b1, 5'd30, 1'b0, 2'b10, 2'b00}, // R2 R5
      {5'd12, 5'd13, 5'd14, 1'b1, 5'd15, 1'b1, 2'b00, 2'b00}  // R1
   };

   localparam logic [DW-1:0] RF_A = 32'h0A0A_0001;
   localparam logic [DW-1:0] RF_B = 32'h0B0B_0002;
   localparam logic [DW-1:0] MEMV = 32'hC0DE_0003;
   localparam logic [DW-1:0] WBV  = 32'h5EED_0004;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [NS-1:0][RW-1:0] ex_src_reg;
   logic [NS-1:0][DW-1:0] ex_src_rfval;
   logic [RW-1:0]         mem_dst_reg;
   logic                  mem_wr_en;
   logic [DW-1:0]         mem_result;
   logic [RW-1:0]         wb_dst_reg;
   logic                  wb_wr_en;
   logic [DW-1:0]         wb_value;
   logic [NS-1:0][RW-1:0] id_src_reg;
   logic [NS-1:0][DW-1:0] id_rf_raw;
   logic [NS-1:0][DW-1:0] id_src_val;
   logic [NS-1:0][1:0]    ex_fwd_sel;
   logic [NS-1:0][DW-1:0] ex_operand;

   fwd_unit #(.DATA_W(DW), .REG_W(RW), .NUM_SRC(NS)) uut (.*);

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf);
      case (s)
         2'b10:   return MEMV;
         2'b01:   return WBV;
         default: return rf;
      endcase
   endfunction

   initial begin
      ex_src_reg   = '0;
      ex_src_rfval = {RF_B, RF_A};
      mem_dst_reg  = '0;
      mem_wr_en    = 1'b0;
      mem_result   = MEMV;
      wb_dst_reg   = '0;
      wb_wr_en     = 1'b0;
      wb_value     = WBV;
      id_src_reg   = '0;
      id_rf_raw    = {32'h1D1D_0002, 32'h1D1D_0001};
      @(negedge clk);
      #1;
      // idle state: nothing forwarded
      chk("R1 idle sel a", 32'(ex_fwd_sel[0]), 32'd0);
      chk("R1 idle sel b", 32'(ex_fwd_sel[1]), 32'd0);
      chk("R1 idle op a", ex_operand[0], RF_A);

      for (int k = 0; k < NV; k++) begin
         logic [25:0] v;
         string tag;
         v = VEC[k];
         @(negedge clk);
         ex_src_reg[0] = v[25:21];
         ex_src_reg[1] = v[20:16];
         mem_dst_reg   = v[15:11];
         mem_wr_en     = v[10];
         wb_dst_reg    = v[9:5];
         wb_wr_en      = v[4];
         #1;
         tag = $sformatf("vec%0d R1 R2 R3 R4 R5 R6 R7 R10", k);
         chk({tag, " sel a"}, 32'(ex_fwd_sel[0]), 32'(v[3:2]));
         chk({tag, " sel b"}, 32'(ex_fwd_sel[1]), 32'(v[1:0]));
         chk({tag, " op a"}, ex_operand[0], pick(v[3:2], RF_A));
         chk({tag, " op b"}, ex_operand[1], pick(v[1:0], RF_B));
      end

      // R8: decode read of register being written
      @(negedge clk);
      id_src_reg[0] = 5'd7;
      id_src_reg[1] = 5'd9;
      wb_dst_reg    = 5'd7;
      wb_wr_en      = 1'b1;
      #1;
      chk("R8 bypass hit", id_src_val[0], WBV);
      chk("R9 bypass other index", id_src_val[1], 32'h1D1D_0002);

      // R9: enable low
      @(negedge clk);
      wb_wr_en = 1'b0;
      #1;
      chk("R9 bypass enable low", id_src_val[0], 32'h1D1D_0001);

      // R6: index zero never bypassed
      @(negedge clk);
      id_src_reg[0] = 5'd0;
      wb_dst_reg    = 5'd0;
      wb_wr_en      = 1'b1;
      #1;
      chk("R6 bypass reg zero", id_src_val[0], 32'h1D1D_0001);

      // R4 with differing values on both forwarding paths, second operand
      @(negedge clk);
      ex_src_reg[1] = 5'd17;
      ex_src_reg[0] = 5'd18;
      mem_dst_reg   = 5'd17;
      mem_wr_en     = 1'b1;
      wb_dst_reg    = 5'd17;
      wb_wr_en      = 1'b1;
      #1;
      chk("R4 both stages op b", ex_operand[1], MEMV);
      chk("R1 unmatched op a", ex_operand[0], RF_A);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule